// File: doc/BRIEF.md
# Priority-Masking Interrupt Accept and End-of-Interrupt Unit

This unit puts sixteen priority levels on top of a flat 32-line interrupt enable register. Software configures each line with an enable flag and a 4-bit priority. The unit then keeps three pieces of state: a table that holds one line mask per level, the set of lines that are configured as enabled, and the level currently in service. Larger priority numbers preempt smaller ones.

When the processor requests an accept, the unit looks at the raw sources gated by the hardware enable register. It picks the lowest-numbered pending line and clears from the enable register every line in the mask of that line's level. It returns the level it was running at as a token and moves the current level to the chosen line's priority.

An end-of-interrupt request carries that token back. The unit returns to the token's level and re-opens every configured line that the token level's mask does not block. Nested preemption therefore works with a plain stack of tokens kept by software. A separate mask input lets software gate a single line without touching its configuration.

Top module: `ipm_prio_ctrl`

## Requirements
- R1: After reset, line_en is all zero, cur_level is 0, and acc_done, cfg_err and irq_pend are 0.
- R2: A configuration write with cfg_line below 32, cfg_enable=1 and priority p has the following effects. It records p as the line's priority and adds the line to the enabled set. It sets the line's bit in the mask of every level from p through 15. It sets line_en[cfg_line] on the next cycle.
- R3: A configuration write with cfg_line below 32 and cfg_enable=0 clears line_en[cfg_line] on the next cycle. It also removes the line from the enabled set and from the mask of every level.
- R4: A configuration write with cfg_line of 32 or more raises cfg_err for exactly one cycle and changes no state: line_en, cur_level, the priorities and the table are unchanged.
- R5: An accept performed while (irq_raw & line_en) is zero returns acc_done=1 and acc_hit=0, and leaves line_en and cur_level unchanged.
- R6: An accept performed while (irq_raw & line_en) is non-zero returns acc_hit=1, and acc_line is the index of the lowest-numbered set bit.
- R7: On a hit, acc_token holds the previous cur_level and cur_level becomes the chosen line's priority. Every line in that level's mask is cleared in line_en.
- R8: An end-of-interrupt with token t sets cur_level to t. It sets in line_en every line of the enabled set that is absent from the mask of level t.
- R9: A mask request (msk_open=0 clears, msk_open=1 sets) changes only line_en[msk_line]. The priority, the enabled set and the table are untouched.
- R10: Only one request is served per cycle, in the order configuration, end-of-interrupt, accept, mask. A request that loses in a cycle has no effect, and acc_done stays 0 when the accept loses.
- R11: irq_pend equals the OR of (irq_raw & line_en) as sampled at the previous clock edge.
- R12: Re-enabling a line with a larger priority number records the new priority but leaves the line's bits set in the lower levels where an earlier enable put them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_raw | input | 32 | Raw interrupt source levels |
| cfg_valid | input | 1 | Configuration write request |
| cfg_line | input | 6 | Line index for the configuration write (32 and above rejected) |
| cfg_enable | input | 1 | 1 enables the line, 0 disables it |
| cfg_prio | input | 4 | Priority for an enable write |
| msk_valid | input | 1 | Single-line mask request |
| msk_line | input | 5 | Line index for the mask request |
| msk_open | input | 1 | 1 sets the line's enable bit, 0 clears it |
| acc_req | input | 1 | Accept request |
| eoi_valid | input | 1 | End-of-interrupt request |
| eoi_token | input | 4 | Level to return to |
| acc_done | output | 1 | Pulses one cycle after an accept is served |
| acc_hit | output | 1 | The served accept found a pending line |
| acc_line | output | 5 | Index of the accepted line |
| acc_token | output | 4 | Level in force before the accept |
| cfg_err | output | 1 | Pulses after a rejected configuration write |
| irq_pend | output | 1 | Any enabled line pending |
| line_en | output | 32 | Hardware enable register |
| cur_level | output | 4 | Level currently in service |

## Verification
The embedded properties check three things on every cycle. The per-level masks stay nested, with each level a subset of the level above. Every enable and disable write lands in all the affected levels. The selector always returns the lowest pending line. Further properties check after every served request that an accepted line is closed, that the token carries the old level, that end-of-interrupt installs its token as the level, that rejected writes leave state alone, and that a losing accept reports nothing. Only the directed scenarios can show the combined effects. These are the exact line_en patterns produced by three-deep nesting and unwinding, the sticky lower-level bits left by a re-enable at a larger priority, and a line opened by the mask input surviving an accept because its configuration was removed. They also cover EOI reopening a line that the mask input had closed, and the order in which simultaneous requests are served.

// File: rtl/ipm_pkg.sv
package ipm_pkg;

  // request served in a cycle, in decreasing precedence
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_CFG  = 3'd1,
    OP_EOI  = 3'd2,
    OP_ACC  = 3'd3,
    OP_MSK  = 3'd4
  } ipm_op_e;

endpackage

// File: rtl/ipm_op_sel.sv
module ipm_op_sel
  import ipm_pkg::*;
(
  input  logic    cfg_req_i,
  input  logic    eoi_req_i,
  input  logic    acc_req_i,
  input  logic    msk_req_i,
  output ipm_op_e op_o
);

  always_comb begin
    if (cfg_req_i)      op_o = OP_CFG;
    else if (eoi_req_i) op_o = OP_EOI;
    else if (acc_req_i) op_o = OP_ACC;
    else if (msk_req_i) op_o = OP_MSK;
    else                op_o = OP_NONE;
  end

endmodule

// File: rtl/ipm_lowest_set.sv
module ipm_lowest_set #(
  parameter int W  = 32,
  parameter int IW = 5
) (
  input  logic [W-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);

  logic [W:0]   seen;
  logic [W-1:0] first;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_scan
    assign first[i]  = vec_i[i] & ~seen[i];
    assign seen[i+1] = seen[i] | vec_i[i];
  end

  assign any_o = seen[W];

  // encode the one-hot winner
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (first[i]) idx_o = idx_o | IW'(i);
    end
  end

  // R6: the chosen bit is set and nothing below it is
  always_comb begin
    if (any_o) begin
      p_lowest_pick_r6: assert (vec_i[idx_o] &&
                                ((vec_i & ((W'(1) << idx_o) - W'(1))) == '0))
        else $error("lowest-set selector returned a wrong index");
    end
  end

endmodule

// File: rtl/ipm_level_table.sv
module ipm_level_table #(
  parameter int NL = 32,
  parameter int NV = 16,
  parameter int LW = 4,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_line,
  input  logic          wr_set,
  input  logic [LW-1:0] wr_prio,
  input  logic [IW-1:0] rd_line,
  output logic [LW-1:0] rd_prio,
  output logic [NL-1:0] rd_mask,
  input  logic [LW-1:0] lvl_b,
  output logic [NL-1:0] mask_b
);

  logic [NL-1:0] lvl_mask_q [NV];
  logic [LW-1:0] prio_q     [NL];

  // per-line priority, one entry written per cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NL; i++) prio_q[i] <= '0;
    end else if (wr_en && wr_set) begin
      prio_q[wr_line] <= wr_prio;
    end
  end

  // one mask row per level; an enable fills levels at and above its priority
  for (genvar k = 0; k < NV; k++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (rst) begin
        lvl_mask_q[k] <= '0;
      end else if (wr_en) begin
        if (!wr_set)
          lvl_mask_q[k][wr_line] <= 1'b0;
        else if (LW'(k) >= wr_prio)
          lvl_mask_q[k][wr_line] <= 1'b1;
      end
    end

    // R2: an enable reaches every level from its priority upward
    p_fill_up_r2: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_set && (wr_prio <= LW'(k))) |=> lvl_mask_q[k][$past(wr_line)])
      else $error("enable write missed a level");

    // R3: a disable removes the line from every level
    p_clear_all_r3: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wr_set) |=> !lvl_mask_q[k][$past(wr_line)])
      else $error("disable write left a level bit");

    if (k < NV - 1) begin : g_nest
      // R12: lower levels always nest inside higher ones
      p_nested_r12: assert property (@(posedge clk) disable iff (rst)
        (lvl_mask_q[k] & ~lvl_mask_q[k+1]) == '0)
        else $error("level masks are not nested");
    end
  end

  assign rd_prio = prio_q[rd_line];
  assign rd_mask = lvl_mask_q[rd_prio];
  assign mask_b  = lvl_mask_q[lvl_b];

endmodule

// File: rtl/ipm_prio_ctrl.sv
module ipm_prio_ctrl
  import ipm_pkg::*;
#(
  parameter int N_LINES  = 32,
  parameter int N_LEVELS = 16,
  localparam int LVL_W   = $clog2(N_LEVELS),
  localparam int IDX_W   = $clog2(N_LINES),
  localparam int CFG_W   = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_raw,
  input  logic               cfg_valid,
  input  logic [CFG_W-1:0]   cfg_line,
  input  logic               cfg_enable,
  input  logic [LVL_W-1:0]   cfg_prio,
  input  logic               msk_valid,
  input  logic [IDX_W-1:0]   msk_line,
  input  logic               msk_open,
  input  logic               acc_req,
  input  logic               eoi_valid,
  input  logic [LVL_W-1:0]   eoi_token,
  output logic               acc_done,
  output logic               acc_hit,
  output logic [IDX_W-1:0]   acc_line,
  output logic [LVL_W-1:0]   acc_token,
  output logic               cfg_err,
  output logic               irq_pend,
  output logic [N_LINES-1:0] line_en,
  output logic [LVL_W-1:0]   cur_level
);

  ipm_op_e op;

  logic [N_LINES-1:0] en_q, en_d;
  logic [N_LINES-1:0] set_q, set_d;
  logic [LVL_W-1:0]   lvl_q, lvl_d;
  logic [N_LINES-1:0] status;
  logic               any_pend;
  logic [IDX_W-1:0]   first_idx;
  logic               cfg_ok;
  logic [IDX_W-1:0]   cfg_idx;
  logic [N_LINES-1:0] cfg_bit, msk_bit;
  logic [LVL_W-1:0]   win_prio;
  logic [N_LINES-1:0] win_mask, eoi_mask;
  logic               tbl_wr;

  assign status  = irq_raw & en_q;
  assign cfg_ok  = cfg_line < CFG_W'(N_LINES);
  assign cfg_idx = cfg_line[IDX_W-1:0];
  assign cfg_bit = N_LINES'(1) << cfg_idx;
  assign msk_bit = N_LINES'(1) << msk_line;
  assign tbl_wr  = (op == OP_CFG) && cfg_ok;

  ipm_op_sel u_sel (
    .cfg_req_i (cfg_valid),
    .eoi_req_i (eoi_valid),
    .acc_req_i (acc_req),
    .msk_req_i (msk_valid),
    .op_o      (op)
  );

  ipm_lowest_set #(.W(N_LINES), .IW(IDX_W)) u_pick (
    .vec_i (status),
    .any_o (any_pend),
    .idx_o (first_idx)
  );

  ipm_level_table #(.NL(N_LINES), .NV(N_LEVELS), .LW(LVL_W), .IW(IDX_W)) u_tbl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (tbl_wr),
    .wr_line (cfg_idx),
    .wr_set  (cfg_enable),
    .wr_prio (cfg_prio),
    .rd_line (first_idx),
    .rd_prio (win_prio),
    .rd_mask (win_mask),
    .lvl_b   (eoi_token),
    .mask_b  (eoi_mask)
  );

  // next-state of enable register, enabled set and level
  always_comb begin
    en_d  = en_q;
    set_d = set_q;
    lvl_d = lvl_q;
    unique case (op)
      OP_CFG: begin
        if (cfg_ok) begin
          if (cfg_enable) begin
            en_d  = en_q  | cfg_bit;
            set_d = set_q | cfg_bit;
          end else begin
            en_d  = en_q  & ~cfg_bit;
            set_d = set_q & ~cfg_bit;
          end
        end
      end
      OP_EOI: begin
        lvl_d = eoi_token;
        en_d  = en_q | (set_q & ~eoi_mask);
      end
      OP_ACC: begin
        if (any_pend) begin
          lvl_d = win_prio;
          en_d  = en_q & ~win_mask;
        end
      end
      OP_MSK: begin
        en_d = msk_open ? (en_q | msk_bit) : (en_q & ~msk_bit);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      set_q     <= '0;
      lvl_q     <= '0;
      acc_done  <= 1'b0;
      acc_hit   <= 1'b0;
      acc_line  <= '0;
      acc_token <= '0;
      cfg_err   <= 1'b0;
      irq_pend  <= 1'b0;
    end else begin
      en_q     <= en_d;
      set_q    <= set_d;
      lvl_q    <= lvl_d;
      acc_done <= (op == OP_ACC);
      cfg_err  <= (op == OP_CFG) && !cfg_ok;
      irq_pend <= |status;
      if (op == OP_ACC) begin
        acc_hit   <= any_pend;
        acc_line  <= any_pend ? first_idx : '0;
        acc_token <= lvl_q;
      end
    end
  end

  assign line_en   = en_q;
  assign cur_level = lvl_q;

  // R4: rejected write flags an error and leaves state alone
  p_reject_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && !cfg_ok) |=> (cfg_err && $stable(line_en) && $stable(cur_level)))
    else $error("rejected configuration changed state");

  // R5: an empty accept reports a miss and keeps the level
  p_miss_r5: assert property (@(posedge clk) disable iff (rst)
    ((op == OP_ACC) && (status == '0)) |=> (acc_done && !acc_hit && $stable(cur_level)))
    else $error("empty accept misbehaved");

  // R7: a hit closes its own line and hands back the previous level
  p_hit_r7: assert property (@(posedge clk) disable iff (rst)
    ((op == OP_ACC) && (status != '0)) |=>
      (acc_hit && !line_en[acc_line] && acc_token == $past(cur_level)))
    else $error("accept did not close line or return token");

  // R8: end-of-interrupt installs its token as the level
  p_eoi_level_r8: assert property (@(posedge clk) disable iff (rst)
    (eoi_valid && !cfg_valid) |=> cur_level == $past(eoi_token))
    else $error("end-of-interrupt did not restore level");

  // R10: a configuration write pre-empts an accept in the same cycle
  p_cfg_first_r10: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |=> !acc_done)
    else $error("accept served alongside configuration");

endmodule

// File: tb/sim_ipm_prio_ctrl.sv
module sim_ipm_prio_ctrl;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] irq_raw;
  logic        cfg_valid;
  logic [5:0]  cfg_line;
  logic        cfg_enable;
  logic [3:0]  cfg_prio;
  logic        msk_valid;
  logic [4:0]  msk_line;
  logic        msk_open;
  logic        acc_req;
  logic        eoi_valid;
  logic [3:0]  eoi_token;
  logic        acc_done, acc_hit, cfg_err, irq_pend;
  logic [4:0]  acc_line;
  logic [3:0]  acc_token, cur_level;
  logic [31:0] line_en;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ipm_prio_ctrl u0 (
    .clk(clk), .rst(rst), .irq_raw(irq_raw),
    .cfg_valid(cfg_valid), .cfg_line(cfg_line), .cfg_enable(cfg_enable), .cfg_prio(cfg_prio),
    .msk_valid(msk_valid), .msk_line(msk_line), .msk_open(msk_open),
    .acc_req(acc_req), .eoi_valid(eoi_valid), .eoi_token(eoi_token),
    .acc_done(acc_done), .acc_hit(acc_hit), .acc_line(acc_line), .acc_token(acc_token),
    .cfg_err(cfg_err), .irq_pend(irq_pend), .line_en(line_en), .cur_level(cur_level)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_req();
    cfg_valid = 0; msk_valid = 0; acc_req = 0; eoi_valid = 0;
  endtask

  // inputs change on falling edges; results read one falling edge later
  task automatic step();
    @(negedge clk);
    clear_req();
  endtask

  task automatic do_reset();
    @(negedge clk);
    clear_req();
    irq_raw = '0; cfg_line = '0; cfg_enable = 0; cfg_prio = '0;
    msk_line = '0; msk_open = 0; eoi_token = '0;
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic cfg(input int line, input bit en, input int prio);
    cfg_valid = 1; cfg_line = 6'(line); cfg_enable = en; cfg_prio = 4'(prio);
    step();
  endtask

  task automatic acc();
    acc_req = 1;
    step();
  endtask

  task automatic eoi(input int tok);
    eoi_valid = 1; eoi_token = 4'(tok);
    step();
  endtask

  task automatic msk(input int line, input bit open);
    msk_valid = 1; msk_line = 5'(line); msk_open = open;
    step();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 line_en", line_en, 0);
    chk("R1 cur_level", 32'(cur_level), 0);
    chk("R1 acc_done", 32'(acc_done), 0);
    chk("R1 cfg_err", 32'(cfg_err), 0);
    chk("R1 irq_pend", 32'(irq_pend), 0);
  endtask

  task automatic t_cfg();
    do_reset();
    cfg(5, 1, 7);  chk("R2 enable line 5", line_en, 32'h20);
    cfg(9, 1, 2);  chk("R2 enable line 9", line_en, 32'h220);
    cfg(5, 0, 0);  chk("R3 disable line 5", line_en, 32'h200);
    msk(5, 1);     chk("R9 mask input opens line 5", line_en, 32'h220);
    irq_raw = 32'h200;
    acc();
    chk("R6 hit", 32'(acc_hit), 1);
    chk("R6 line", 32'(acc_line), 9);
    chk("R7 token", 32'(acc_token), 0);
    chk("R7 level", 32'(cur_level), 2);
    chk("R3 removed line survives accept", line_en, 32'h20);
    irq_raw = '0;
    eoi(0);
    chk("R8 level", 32'(cur_level), 0);
    chk("R8 reopen", line_en, 32'h220);
  endtask

  task automatic t_reject();
    do_reset();
    cfg(5, 1, 3);
    cfg(37, 1, 1);
    chk("R4 err on 37", 32'(cfg_err), 1);
    chk("R4 line_en unchanged", line_en, 32'h20);
    cfg(32, 0, 0);
    chk("R4 err on 32", 32'(cfg_err), 1);
    chk("R4 line_en still", line_en, 32'h20);
    step();
    chk("R4 err single cycle", 32'(cfg_err), 0);
    irq_raw = 32'h20;
    acc();
    chk("R4 priority of line 5 kept", 32'(cur_level), 3);
    irq_raw = '0;
  endtask

  task automatic t_miss();
    do_reset();
    cfg(3, 1, 4);
    irq_raw = 32'h40;
    acc();
    chk("R5 done", 32'(acc_done), 1);
    chk("R5 no hit", 32'(acc_hit), 0);
    chk("R5 level", 32'(cur_level), 0);
    chk("R5 line_en", line_en, 32'h8);
    irq_raw = '0;
  endtask

  task automatic t_nest();
    do_reset();
    cfg(2, 1, 3); cfg(4, 1, 5); cfg(10, 1, 9); cfg(20, 1, 12);
    chk("R2 four lines", line_en, 32'h100414);
    irq_raw = 32'h100410;
    acc();
    chk("R6 first line", 32'(acc_line), 4);
    chk("R7 first token", 32'(acc_token), 0);
    chk("R7 first level", 32'(cur_level), 5);
    chk("R7 first mask", line_en, 32'h100400);
    acc();
    chk("R6 second line", 32'(acc_line), 10);
    chk("R7 second token", 32'(acc_token), 5);
    chk("R7 second mask", line_en, 32'h100000);
    acc();
    chk("R6 third line", 32'(acc_line), 20);
    chk("R7 third token", 32'(acc_token), 9);
    chk("R7 third level", 32'(cur_level), 12);
    chk("R7 third mask", line_en, 0);
    acc();
    chk("R5 nothing left", 32'(acc_hit), 0);
    chk("R5 level kept", 32'(cur_level), 12);
    eoi(9);
    chk("R8 unwind 9 level", 32'(cur_level), 9);
    chk("R8 unwind 9 mask", line_en, 32'h100000);
    eoi(5);
    chk("R8 unwind 5 mask", line_en, 32'h100400);
    eoi(0);
    chk("R8 unwind 0 mask", line_en, 32'h100414);
    chk("R8 unwind 0 level", 32'(cur_level), 0);
    irq_raw = '0;
  endtask

  task automatic t_sticky();
    do_reset();
    cfg(2, 1, 3); cfg(2, 1, 8); cfg(4, 1, 5);
    irq_raw = 32'h10;
    acc();
    chk("R12 level 5 still holds line 2", line_en, 0);
    eoi(0);
    chk("R12 reopen", line_en, 32'h14);
    irq_raw = 32'h4;
    acc();
    chk("R12 new priority used", 32'(cur_level), 8);
    chk("R12 level 8 mask", line_en, 0);
    irq_raw = '0;
  endtask

  task automatic t_order();
    do_reset();
    cfg(1, 1, 6);
    irq_raw = 32'h2;
    cfg_valid = 1; cfg_line = 6'd7; cfg_enable = 1; cfg_prio = 4'd2; acc_req = 1;
    step();
    chk("R10 cfg beats accept done", 32'(acc_done), 0);
    chk("R10 cfg beats accept level", 32'(cur_level), 0);
    chk("R10 cfg applied", line_en, 32'h82);
    acc();
    chk("R7 accept line 1 masks both", line_en, 0);
    eoi_valid = 1; eoi_token = 4'd0; acc_req = 1;
    step();
    chk("R10 eoi beats accept done", 32'(acc_done), 0);
    chk("R10 eoi served", line_en, 32'h82);
    acc();
    cfg_valid = 1; cfg_line = 6'd12; cfg_enable = 1; cfg_prio = 4'd0;
    eoi_valid = 1; eoi_token = 4'd0;
    step();
    chk("R10 cfg beats eoi level", 32'(cur_level), 6);
    chk("R10 cfg beats eoi mask", line_en, 32'h1000);
    msk_valid = 1; msk_line = 5'd1; msk_open = 1; acc_req = 1;
    irq_raw = 32'h1000;
    step();
    chk("R10 accept beats mask", line_en, 32'h0);
    irq_raw = '0;
  endtask

  task automatic t_pend();
    do_reset();
    cfg(6, 1, 1);
    irq_raw = 32'h40;
    step();
    chk("R11 pending", 32'(irq_pend), 1);
    irq_raw = 32'h80;
    step(); step();
    chk("R11 disabled source", 32'(irq_pend), 0);
    irq_raw = 32'h40;
    msk(6, 0);
    step();
    chk("R11 masked source", 32'(irq_pend), 0);
    irq_raw = '0;
  endtask

  task automatic t_mask_keep();
    do_reset();
    cfg(3, 1, 2); cfg(8, 1, 5);
    msk(3, 0);
    chk("R9 mask clears bit", line_en, 32'h100);
    irq_raw = 32'h100;
    acc();
    chk("R9 level", 32'(cur_level), 5);
    chk("R9 table kept", line_en, 0);
    eoi(0);
    chk("R9 set kept so eoi reopens line 3", line_en, 32'h108);
    msk(8, 0); msk(8, 1);
    acc();
    chk("R9 priority kept", 32'(cur_level), 5);
    irq_raw = '0;
  endtask

  initial begin
    rst = 1;
    clear_req();
    irq_raw = '0;
    t_reset();
    t_cfg();
    t_reject();
    t_miss();
    t_nest();
    t_sticky();
    t_order();
    t_pend();
    t_mask_keep();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL R1 watchdog: got running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule